// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses global register sets and overlapping register windows. An access names a register by a small architectural number. The block turns that number into a flat physical entry of one storage array. The mapping also uses the current global-set selector (`gl`), the current window pointer (`cwp`) and a per-port view code. The view code picks the current window, the one below it or the one above it. The array holds every global set first, then the circular window region, then a block of scratch registers used by microcode.

There are two combinational read ports and one write port that commits on the clock edge. Every port has its own flattener, and every port reports combinationally when the number or view it was given does not exist. Architectural register 0 reads as zero. An illegal access reads zero and writes nothing. Window overflow handling and window bookkeeping counters belong to the surrounding core and are not part of this block.

Top module: `wrf_regfile`

## Requirements
- R1: Asynchronous active-low reset clears every physical entry to zero, so any read after reset and before a write returns zero.
- R2: Indices 0 to 7 are globals. Index i in global set g uses physical entry g*8+i. Each of the MAXGL+1 sets is separate storage, and the view code has no effect on globals.
- R3: Index 0 reads as zero in every global set, and a write to index 0 changes no entry.
- R4: Indices 8 to 31 with view 0 use physical entry (MAXGL+1)*8 + ((idx - 8 - cwp*16) mod (NWIN*16)). As a result, indices 8..15 of window c share storage with indices 24..31 of window c+1 (mod NWIN), while indices 16..23 are private to each window.
- R5: View code 1 maps windowed indices as if cwp were cwp-1, and view code 2 as if cwp were cwp+1, both modulo NWIN.
- R6: Indices 32 to 32+NMICRO-1 use physical entry (MAXGL+1)*8 + NWIN*16 + (idx-32), whatever the values of gl, cwp and the view.
- R7: An index of 32+NMICRO or above, or view code 3, raises that port's illegal output in the same cycle, and a read on that port returns zero.
- R8: A write whose index or view is illegal changes no entry.
- R9: A write takes effect at the rising clock edge. A read of the same entry in the same cycle returns the old value.
- R10: The two read ports resolve independently, each with its own index and view, under the shared gl and cwp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gl | input | GLW | Current global-set selector |
| cwp | input | CWPW | Current window pointer |
| rd_a_idx | input | IDXW | Read port A architectural index |
| rd_a_view | input | 2 | Read port A view: 0 current, 1 previous, 2 next, 3 illegal |
| rd_a_data | output | DW | Read port A data |
| rd_a_illegal | output | 1 | Read port A index or view illegal |
| rd_b_idx | input | IDXW | Read port B architectural index |
| rd_b_view | input | 2 | Read port B view |
| rd_b_data | output | DW | Read port B data |
| rd_b_illegal | output | 1 | Read port B index or view illegal |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDXW | Write architectural index |
| wr_view | input | 2 | Write view |
| wr_data | input | DW | Write data |
| wr_illegal | output | 1 | Write index or view illegal |

## Verification
Directed steps cover the cases that separate one mapping error from another. A write to the outs of one window is read back through the ins of the next window, and a private local is read from a neighbouring window. A previous-view write at window 0 is read as the current view of the last window, which exercises the wrap. A global written in one set is read from another set, and scratch registers are used under different gl and cwp values. Writes to index 0 and illegal writes are followed by reads of every place they could have reached. A read of the same entry as a write in the same cycle shows the absence of a bypass. Random traffic with a fixed seed then varies gl, cwp, indices (some out of range) and views on all three ports. Every read is compared with a bench model of the flattening formula, which catches off-by-one window offsets, a wrong wrap direction and set aliasing.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
   localparam int ARCH_REGS = 32;
   localparam int GLB_PER_SET = 8;
   localparam int WIN_NEW = 16;

   typedef enum logic [1:0] {
      VIEW_CUR  = 2'd0,
      VIEW_PREV = 2'd1,
      VIEW_NEXT = 2'd2,
      VIEW_RSVD = 2'd3
   } view_e;
endpackage

// File: rtl/wrf_flatten.sv
module wrf_flatten
   import wrf_pkg::*;
#(
   parameter int NWIN   = 8,
   parameter int MAXGL  = 3,
   parameter int NMICRO = 8,
   parameter int IDXW   = 6,
   parameter int GLW    = 2,
   parameter int CWPW   = 3,
   parameter int PIDXW  = 8
) (
   input  logic [GLW-1:0]   gl,
   input  logic [CWPW-1:0]  cwp,
   input  logic [IDXW-1:0]  idx,
   input  logic [1:0]       view,
   output logic [PIDXW-1:0] phys,
   output logic             illegal
);
   localparam int NUM_GLB    = (MAXGL + 1) * GLB_PER_SET;
   localparam int WIN_SZ     = NWIN * WIN_NEW;
   localparam int WOFFW      = CWPW + 4;
   localparam int MICRO_BASE = NUM_GLB + WIN_SZ;
   localparam int LIMIT      = ARCH_REGS + NMICRO;

   logic [CWPW-1:0]  wcwp;
   logic [WOFFW-1:0] woff;
   logic [PIDXW-1:0] glb;
   logic             is_glb, is_win;

   always_comb begin
      case (view_e'(view))
         VIEW_PREV: wcwp = cwp - CWPW'(1);
         VIEW_NEXT: wcwp = cwp + CWPW'(1);
         default:   wcwp = cwp;
      endcase
      // power-of-two window region: modulo is the natural wrap
      woff   = WOFFW'(idx[4:0]) - WOFFW'(8) - {wcwp, 4'b0000};
      glb    = (PIDXW'(gl) << 3) | PIDXW'(idx[2:0]);
      is_glb = int'(idx) < GLB_PER_SET;
      is_win = !is_glb && (int'(idx) < ARCH_REGS);
      illegal = (view == 2'd3) || (int'(idx) >= LIMIT) ||
                (is_glb && (int'(gl) > MAXGL));
      if (is_glb)      phys = glb;
      else if (is_win) phys = PIDXW'(NUM_GLB) + PIDXW'(woff);
      else             phys = PIDXW'(MICRO_BASE) + PIDXW'(idx - IDXW'(ARCH_REGS));
      if (illegal) phys = '0;
   end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
   parameter int DEPTH = 168,
   parameter int DW    = 64,
   parameter int AW    = 8,
   parameter int NRD   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0][DW-1:0]  rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata[r] = mem[raddr[r]];
   end
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile #(
   parameter int NWIN   = 8,
   parameter int MAXGL  = 3,
   parameter int NMICRO = 8,
   parameter int DW     = 64,
   parameter int GLW    = $clog2(MAXGL + 1),
   parameter int CWPW   = $clog2(NWIN),
   parameter int IDXW   = $clog2(33 + NMICRO)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GLW-1:0]   gl,
   input  logic [CWPW-1:0]  cwp,
   input  logic [IDXW-1:0]  rd_a_idx,
   input  logic [1:0]       rd_a_view,
   output logic [DW-1:0]    rd_a_data,
   output logic             rd_a_illegal,
   input  logic [IDXW-1:0]  rd_b_idx,
   input  logic [1:0]       rd_b_view,
   output logic [DW-1:0]    rd_b_data,
   output logic             rd_b_illegal,
   input  logic             wr_en,
   input  logic [IDXW-1:0]  wr_idx,
   input  logic [1:0]       wr_view,
   input  logic [DW-1:0]    wr_data,
   output logic             wr_illegal
);
   localparam int NPORT = 3;
   localparam int PHYS  = (MAXGL + 1) * 8 + NWIN * 16 + NMICRO;
   localparam int PIDXW = $clog2(PHYS);

   if (NWIN < 2 || (NWIN & (NWIN - 1)) != 0) begin : g_bad_nwin
      $error("NWIN must be a power of two, at least 2");
   end
   if (MAXGL < 1) begin : g_bad_maxgl
      $error("MAXGL must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [NPORT-1:0][IDXW-1:0]  p_idx;
   logic [NPORT-1:0][1:0]       p_view;
   logic [NPORT-1:0][PIDXW-1:0] p_phys;
   logic [NPORT-1:0]            p_ill;
   logic [1:0][DW-1:0]          rd_raw;
   logic                        wr_commit;

   assign p_idx  = {wr_idx, rd_b_idx, rd_a_idx};
   assign p_view = {wr_view, rd_b_view, rd_a_view};

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      wrf_flatten #(
         .NWIN(NWIN), .MAXGL(MAXGL), .NMICRO(NMICRO),
         .IDXW(IDXW), .GLW(GLW), .CWPW(CWPW), .PIDXW(PIDXW)
      ) u_flat (
         .gl(gl), .cwp(cwp), .idx(p_idx[i]), .view(p_view[i]),
         .phys(p_phys[i]), .illegal(p_ill[i])
      );
   end

   assign wr_commit = wr_en && !p_ill[2] && (wr_idx != '0);

   wrf_store #(.DEPTH(PHYS), .DW(DW), .AW(PIDXW), .NRD(2)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_commit), .waddr(p_phys[2]), .wdata(wr_data),
      .raddr({p_phys[1], p_phys[0]}), .rdata(rd_raw)
   );

   assign rd_a_data    = (p_ill[0] || rd_a_idx == '0) ? '0 : rd_raw[0];
   assign rd_b_data    = (p_ill[1] || rd_b_idx == '0) ? '0 : rd_raw[1];
   assign rd_a_illegal = p_ill[0];
   assign rd_b_illegal = p_ill[1];
   assign wr_illegal   = p_ill[2];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
   parameter int NWIN   = 8,
   parameter int MAXGL  = 3,
   parameter int NMICRO = 8,
   parameter int DW     = 64,
   parameter int GLW    = 2,
   parameter int CWPW   = 3,
   parameter int IDXW   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [GLW-1:0]   gl,
   input logic [CWPW-1:0]  cwp,
   input logic [IDXW-1:0]  rd_a_idx,
   input logic [1:0]       rd_a_view,
   input logic [DW-1:0]    rd_a_data,
   input logic             rd_a_illegal,
   input logic [IDXW-1:0]  rd_b_idx,
   input logic [1:0]       rd_b_view,
   input logic [DW-1:0]    rd_b_data,
   input logic             rd_b_illegal,
   input logic             wr_en,
   input logic [IDXW-1:0]  wr_idx,
   input logic [1:0]       wr_view,
   input logic [DW-1:0]    wr_data,
   input logic             wr_illegal
);
   localparam int LIMIT = 32 + NMICRO;

   AST_G0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == '0) |-> (rd_a_data == '0)); // R3

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_a_illegal |-> (rd_a_data == '0)); // R7

   AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_b_idx) >= LIMIT || rd_b_view == 2'd3) |-> rd_b_illegal); // R7

   AST_WINDOW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx >= IDXW'(8) && rd_a_idx <= IDXW'(15) && rd_a_view == 2'd0 &&
       rd_b_idx == rd_a_idx + IDXW'(16) && rd_b_view == 2'd2)
      |-> (rd_a_data == rd_b_data)); // R4

   AST_NO_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en && !wr_illegal) && $stable(gl) && $stable(cwp) &&
       $stable(rd_a_idx) && $stable(rd_a_view)) |-> $stable(rd_a_data)); // R8

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && !wr_illegal && wr_idx != '0) && $stable(gl) && $stable(cwp) &&
       rd_a_idx == $past(wr_idx) && rd_a_view == $past(wr_view))
      |-> (rd_a_data == $past(wr_data))); // R9
endmodule

bind wrf_regfile wrf_checker #(
   .NWIN(NWIN), .MAXGL(MAXGL), .NMICRO(NMICRO), .DW(DW),
   .GLW(GLW), .CWPW(CWPW), .IDXW(IDXW)
) u_chk (.*);

// File: tb/wrf_regfile_test.sv
module wrf_regfile_test;
   localparam int NW = 8, MG = 3, NM = 8, DW = 64;
   localparam int NPHYS = 168;

   logic clk = 0, rst_n = 0;
   logic [1:0] gl = 0;
   logic [2:0] cwp = 0;
   logic [5:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
   logic [1:0] rd_a_view = 0, rd_b_view = 0, wr_view = 0;
   logic [DW-1:0] rd_a_data, rd_b_data, wr_data = 0;
   logic rd_a_illegal, rd_b_illegal, wr_illegal, wr_en = 0;

   int total = 0, fails = 0;
   logic [DW-1:0] ref_mem [NPHYS];

   always #10 clk = ~clk;

   wrf_regfile uut (.*);

   function automatic int flat(int idx, int view, int g, int c);
      int cc;
      if (view == 3 || idx >= 32 + NM) return -1;
      if (idx < 8) return g * 8 + idx;
      if (idx < 32) begin
         cc = c + ((view == 1) ? -1 : (view == 2) ? 1 : 0);
         return (MG + 1) * 8 + ((idx - 8 - cc * 16 + NW * 16) % (NW * 16));
      end
      return (MG + 1) * 8 + NW * 16 + (idx - 32);
   endfunction

   function automatic string cat(int idx, int view);
      if (view == 3 || idx >= 32 + NM) return "R7";
      if (idx == 0) return "R3";
      if (idx < 8) return "R2";
      if (idx < 32) return (view == 0) ? "R4" : "R5";
      return "R6";
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] expect_rd(int idx, int view);
      int p = flat(idx, view, gl, cwp);
      if (p < 0 || idx == 0) return '0;
      return ref_mem[p];
   endfunction

   // drives at negedge, checks combinational reads, then lets the edge commit
   task automatic step(bit we, int widx, int wview, logic [DW-1:0] wd,
                       int aidx, int aview, int bidx, int bview, string tag);
      int p;
      wr_en = we; wr_idx = 6'(widx); wr_view = 2'(wview); wr_data = wd;
      rd_a_idx = 6'(aidx); rd_a_view = 2'(aview);
      rd_b_idx = 6'(bidx); rd_b_view = 2'(bview);
      #1;
      chk(tag == "" ? cat(aidx, aview) : tag, rd_a_data, expect_rd(aidx, aview));
      chk(tag == "" ? "R10" : tag, rd_b_data, expect_rd(bidx, bview));
      chk("R7", DW'(rd_a_illegal), DW'(flat(aidx, aview, gl, cwp) < 0));
      chk("R7", DW'(wr_illegal), DW'(flat(widx, wview, gl, cwp) < 0));
      p = flat(widx, wview, gl, cwp);
      if (we && p >= 0 && widx != 0) ref_mem[p] = wd;
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      #(20 * 200000);
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int k = 0; k < NPHYS; k++) ref_mem[k] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: everything reads zero after reset
      for (int k = 0; k < 40; k++) begin
         cwp = 3'(k % 8); gl = 2'(k % 4);
         step(0, 0, 0, 0, k, k % 3, 39 - k, 0, "R1");
      end
      // R9: same-cycle read sees old value, next cycle sees new one
      gl = 1; cwp = 2;
      step(1, 5, 0, 64'hA5A5_0000_1111_2222, 5, 0, 5, 0, "R9");
      step(0, 0, 0, 0, 5, 0, 5, 0, "R9");
      // R2: another global set is separate
      gl = 2;
      step(0, 0, 0, 0, 5, 0, 5, 1, "R2");
      // R3: write to index 0 discarded
      step(1, 0, 0, 64'hDEAD, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, 0, 0, 2, "R3");
      // R4: outs of window 2 are ins of window 3, locals private
      cwp = 2;
      step(1, 9, 0, 64'h0000_0000_0000_0909, 0, 0, 0, 0, "R4");
      step(1, 17, 0, 64'h0000_0000_0000_1717, 9, 0, 25, 2, "R4");
      cwp = 3;
      step(0, 0, 0, 0, 25, 0, 17, 0, "R4");
      // R5: previous view at window 0 wraps to last window
      cwp = 0;
      step(1, 20, 1, 64'h0000_0000_0000_2020, 0, 0, 0, 0, "R5");
      cwp = 7;
      step(0, 0, 0, 0, 20, 0, 20, 2, "R5");
      // R6: scratch registers ignore gl and cwp
      step(1, 33, 2, 64'h3333, 0, 0, 0, 0, "R6");
      gl = 0; cwp = 4;
      step(0, 0, 0, 0, 33, 1, 33, 0, "R6");
      // R8: illegal writes touch nothing reachable
      step(1, 9, 3, 64'hBAD, 0, 0, 0, 0, "R8");
      step(1, 45, 0, 64'hBAD2, 9, 0, 9, 1, "R8");
      step(0, 0, 0, 0, 9, 2, 39, 0, "R8");
      // R10: ports read different entries independently
      step(0, 0, 0, 0, 33, 0, 20, 1, "R10");
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int wv, av, bv;
         if (n % 16 == 0) begin gl = 2'($urandom % 4); cwp = 3'($urandom % 8); end
         wv = ($urandom % 10 == 0) ? 3 : int'($urandom % 3);
         av = ($urandom % 10 == 0) ? 3 : int'($urandom % 3);
         bv = int'($urandom % 3);
         step($urandom % 2 == 0, int'($urandom % 44), wv, {$urandom, $urandom},
              int'($urandom % 44), av, int'($urandom % 40), bv, "");
      end
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule